// File: doc/BRIEF.md
# Receive Timeslot Map Walker

This block decides, timeslot by timeslot, which channel on the receive side of a TDM bus owns the current slot. A host loads a table of up to 1024 entries. Each entry names a timeslot, a channel (or loopback channel) number and the index of the next entry. Entry 0 is a fixed sentinel that only holds the head of the list. The remaining entries form a singly linked chain sorted by ascending timeslot.

At every frame boundary the walker restarts from the sentinel and fetches the first linked entry. As the timeslot counter moves through the frame, the walker compares the counter with the slot of the entry it holds. On equality it reports the entry's channel, loop flag and slot to the downstream servicing engine, then follows the link. A null link ends the walk until the next frame boundary.

A host write to the table stops matching for the rest of the current frame. The new contents are picked up only at the next frame boundary, so a walk never follows a half-rewritten chain.

Top module: `tdm_slot_map`

## Requirements
- R1: While and after reset, `hit_valid` is 0 and every link is 0, so the list is empty until the host writes it.
- R2: Host word encoding by `host_sel`. 0: bit 15 is the loop flag and bits [CH_W-1:0] are the channel. 1: bits [TS_W-1:0] are the timeslot. 2: bits [PTR_W-1:0] are the link. 3: reserved, and the write changes no stored field.
- R3: In the cycle after `frame_start`, `hit_valid` is 0. The walker then holds the entry named by the link of entry 0, and its first hit comes in the first `ts_valid` cycle whose `ts_count` equals that entry's timeslot.
- R4: A match in cycle t makes `hit_valid` high in cycle t+1, with `hit_chan`, `hit_loop` and `hit_slot` taken from the matched entry, and `hit_slot` equal to the `ts_count` of cycle t.
- R5: After a match the walker holds the entry named by the matched entry's link, so entries on consecutive timeslots produce hits on consecutive cycles.
- R6: After a matched entry with link 0, there are no further hits until the next `frame_start`, and each frame repeats the same walk.
- R7: If the link of entry 0 is 0, a frame produces no hits.
- R8: Entry 0 never produces a hit, whatever timeslot is stored in it.
- R9: The walker advances only on a match. An entry whose timeslot has already gone by in the frame blocks every later entry for the rest of that frame.
- R10: Any host write, including one in a `frame_start` cycle and one to a reserved word, suppresses hits from its own cycle to the end of that frame. The next frame uses the table as written.
- R11: A cycle with `ts_valid` low never produces a hit and does not advance the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host table write strobe |
| host_idx | input | PTR_W | Entry index written |
| host_sel | input | 2 | Word of the entry written (R2) |
| host_wdata | input | 16 | Write data |
| frame_start | input | 1 | Frame boundary pulse, one cycle before slot 0 |
| ts_valid | input | 1 | `ts_count` carries a live timeslot this cycle |
| ts_count | input | TS_W | Current bus timeslot |
| hit_valid | output | 1 | A timeslot matched in the previous cycle |
| hit_chan | output | CH_W | Channel or stream number of the match |
| hit_loop | output | 1 | Match belongs to a loopback channel |
| hit_slot | output | TS_W | Timeslot of the match |

## Verification
The hardest situation to reach from the ports is a table change that lands while a walk is under way. It has to arrive at a chosen slot of a running frame, and the next frame must then be seen to follow the rewritten chain. The stimulus places host writes at a fixed slot index inside a frame and on the frame-boundary cycle itself. An out-of-order chain is built to stall the walk mid-frame. Idle cycles are inserted that carry the same count as the slot that follows, so that an ignored `ts_valid` would show up as an early hit.

// File: rtl/tsmap_pkg.sv
package tsmap_pkg;
  localparam int HOST_W   = 16;
  localparam int LOOP_BIT = 15;

  typedef enum logic [1:0] {
    SEL_CHAN = 2'd0,
    SEL_SLOT = 2'd1,
    SEL_LINK = 2'd2,
    SEL_RSVD = 2'd3
  } word_sel_e;
endpackage

// File: rtl/tsmap_table.sv
module tsmap_table
  import tsmap_pkg::*;
#(
  parameter int N_ENTRY = 1024,
  parameter int TS_W    = 12,
  parameter int CH_W    = 10,
  parameter int PTR_W   = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  widx,
  input  logic [1:0]        wsel,
  input  logic [HOST_W-1:0] wdata,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [PTR_W-1:0]  head_link,
  output logic [TS_W-1:0]   rd_slot,
  output logic [CH_W-1:0]   rd_chan,
  output logic              rd_loop,
  output logic [PTR_W-1:0]  rd_link
);
  logic [TS_W-1:0]  slot_mem [N_ENTRY];
  logic [CH_W-1:0]  chan_mem [N_ENTRY];
  logic             loop_mem [N_ENTRY];
  logic [PTR_W-1:0] link_mem [N_ENTRY];

  word_sel_e sel;
  assign sel = word_sel_e'(wsel);

  // Field extraction from a host word.
  function automatic logic [CH_W-1:0] get_chan(input logic [HOST_W-1:0] w);
    return w[CH_W-1:0];
  endfunction

  function automatic logic [TS_W-1:0] get_slot(input logic [HOST_W-1:0] w);
    return w[TS_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] get_link(input logic [HOST_W-1:0] w);
    return w[PTR_W-1:0];
  endfunction

  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRY; i++) begin
        slot_mem[i] <= '0;
        chan_mem[i] <= '0;
        loop_mem[i] <= 1'b0;
        link_mem[i] <= '0;
      end
    end else if (we) begin
      case (sel)
        SEL_CHAN: begin
          chan_mem[widx] <= get_chan(wdata);
          loop_mem[widx] <= wdata[LOOP_BIT];
        end
        SEL_SLOT: slot_mem[widx] <= get_slot(wdata);
        SEL_LINK: link_mem[widx] <= get_link(wdata);
        default:  ;
      endcase
    end
  end

  assign head_link = link_mem[0];
  assign rd_slot   = slot_mem[rd_idx];
  assign rd_chan   = chan_mem[rd_idx];
  assign rd_loop   = loop_mem[rd_idx];
  assign rd_link   = link_mem[rd_idx];
endmodule

// File: rtl/tsmap_walker.sv
module tsmap_walker #(
  parameter int TS_W  = 12,
  parameter int CH_W  = 10,
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             frame_start,
  input  logic             ts_valid,
  input  logic [TS_W-1:0]  ts_count,
  input  logic [PTR_W-1:0] head_link,
  input  logic [TS_W-1:0]  fetch_slot,
  input  logic [CH_W-1:0]  fetch_chan,
  input  logic             fetch_loop,
  input  logic [PTR_W-1:0] fetch_link,
  output logic [PTR_W-1:0] fetch_idx,
  output logic             walk_active,
  output logic             walk_hit,
  output logic [PTR_W-1:0] cur_idx,
  output logic [TS_W-1:0]  cur_slot,
  output logic [CH_W-1:0]  cur_chan,
  output logic             cur_loop,
  output logic [PTR_W-1:0] cur_link
);
  function automatic logic slot_match(input logic [TS_W-1:0] held,
                                      input logic [TS_W-1:0] now);
    return held == now;
  endfunction

  function automatic logic is_null(input logic [PTR_W-1:0] p);
    return p == '0;
  endfunction

  // At a frame boundary the chain restarts at the head link; otherwise
  // the next entry is the one the held entry points at.
  assign fetch_idx = frame_start ? head_link : cur_link;

  assign walk_hit = walk_active && ts_valid && !host_we && !frame_start &&
                    slot_match(cur_slot, ts_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walk_active <= 1'b0;
      cur_idx     <= '0;
      cur_slot    <= '0;
      cur_chan    <= '0;
      cur_loop    <= 1'b0;
      cur_link    <= '0;
    end else if (host_we) begin
      walk_active <= 1'b0;
    end else if (frame_start || walk_hit) begin
      walk_active <= !is_null(fetch_idx);
      cur_idx     <= fetch_idx;
      cur_slot    <= fetch_slot;
      cur_chan    <= fetch_chan;
      cur_loop    <= fetch_loop;
      cur_link    <= fetch_link;
    end
  end
endmodule

// File: rtl/tsmap_emit.sv
module tsmap_emit #(
  parameter int TS_W = 12,
  parameter int CH_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            walk_hit,
  input  logic [TS_W-1:0] cur_slot,
  input  logic [CH_W-1:0] cur_chan,
  input  logic            cur_loop,
  output logic            hit_valid,
  output logic [CH_W-1:0] hit_chan,
  output logic            hit_loop,
  output logic [TS_W-1:0] hit_slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_chan  <= '0;
      hit_loop  <= 1'b0;
      hit_slot  <= '0;
    end else begin
      hit_valid <= walk_hit;
      if (walk_hit) begin
        hit_chan <= cur_chan;
        hit_loop <= cur_loop;
        hit_slot <= cur_slot;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map #(
  parameter int N_ENTRY = 1024,
  parameter int TS_W    = 12,
  parameter int CH_W    = 10,
  parameter int PTR_W   = $clog2(N_ENTRY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [PTR_W-1:0] host_idx,
  input  logic [1:0]       host_sel,
  input  logic [15:0]      host_wdata,
  input  logic             frame_start,
  input  logic             ts_valid,
  input  logic [TS_W-1:0]  ts_count,
  output logic             hit_valid,
  output logic [CH_W-1:0]  hit_chan,
  output logic             hit_loop,
  output logic [TS_W-1:0]  hit_slot
);
  // Named internal events, used by the bound checker.
  logic [PTR_W-1:0] head_link;
  logic [PTR_W-1:0] fetch_idx;
  logic [TS_W-1:0]  fetch_slot;
  logic [CH_W-1:0]  fetch_chan;
  logic             fetch_loop;
  logic [PTR_W-1:0] fetch_link;
  logic             walk_active;
  logic             walk_hit;
  logic [PTR_W-1:0] cur_idx;
  logic [TS_W-1:0]  cur_slot;
  logic [CH_W-1:0]  cur_chan;
  logic             cur_loop;
  logic [PTR_W-1:0] cur_link;

  tsmap_table #(
    .N_ENTRY(N_ENTRY), .TS_W(TS_W), .CH_W(CH_W), .PTR_W(PTR_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(host_we), .widx(host_idx), .wsel(host_sel), .wdata(host_wdata),
    .rd_idx(fetch_idx), .head_link(head_link),
    .rd_slot(fetch_slot), .rd_chan(fetch_chan),
    .rd_loop(fetch_loop), .rd_link(fetch_link)
  );

  tsmap_walker #(
    .TS_W(TS_W), .CH_W(CH_W), .PTR_W(PTR_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .frame_start(frame_start),
    .ts_valid(ts_valid), .ts_count(ts_count), .head_link(head_link),
    .fetch_slot(fetch_slot), .fetch_chan(fetch_chan),
    .fetch_loop(fetch_loop), .fetch_link(fetch_link),
    .fetch_idx(fetch_idx), .walk_active(walk_active), .walk_hit(walk_hit),
    .cur_idx(cur_idx), .cur_slot(cur_slot), .cur_chan(cur_chan),
    .cur_loop(cur_loop), .cur_link(cur_link)
  );

  tsmap_emit #(
    .TS_W(TS_W), .CH_W(CH_W)
  ) u_emit (
    .clk(clk), .rst_n(rst_n),
    .walk_hit(walk_hit), .cur_slot(cur_slot),
    .cur_chan(cur_chan), .cur_loop(cur_loop),
    .hit_valid(hit_valid), .hit_chan(hit_chan),
    .hit_loop(hit_loop), .hit_slot(hit_slot)
  );
endmodule

// File: rtl/tdm_slot_map_checks.sv
module tdm_slot_map_checks #(
  parameter int TS_W  = 12,
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic             frame_start,
  input logic             ts_valid,
  input logic [TS_W-1:0]  ts_count,
  input logic             hit_valid,
  input logic [TS_W-1:0]  hit_slot,
  input logic [PTR_W-1:0] head_link,
  input logic             walk_active,
  input logic             walk_hit,
  input logic [PTR_W-1:0] cur_idx,
  input logic [PTR_W-1:0] cur_link
);
  p_hit_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> ($past(ts_valid) && ($past(ts_count) == hit_slot)));

  p_frame_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !hit_valid);

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_hit && cur_link != '0) |=> (walk_active && cur_idx == $past(cur_link)));

  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_hit && cur_link == '0) |=> !walk_active);

  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && head_link == '0) |=> !walk_active);

  p_sentinel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    walk_active |-> (cur_idx != '0));

  p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> (!hit_valid && !walk_active));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_valid |=> !hit_valid);
endmodule

bind tdm_slot_map tdm_slot_map_checks #(
  .TS_W(TS_W), .PTR_W(PTR_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .frame_start(frame_start),
  .ts_valid(ts_valid), .ts_count(ts_count), .hit_valid(hit_valid),
  .hit_slot(hit_slot), .head_link(head_link), .walk_active(walk_active),
  .walk_hit(walk_hit), .cur_idx(cur_idx), .cur_link(cur_link)
);

// File: tb/tdm_slot_map_bench.sv
module tdm_slot_map_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int N_ENTRY     = 1024;
  localparam int TS_W        = 12;
  localparam int CH_W        = 10;
  localparam int PTR_W       = 10;
  localparam int FRAME_SLOTS = 64;
  localparam int WATCHDOG    = 20000;
  localparam int N_VEC       = 6;

  // Load vectors: {index, timeslot, loop flag, channel, link}.
  localparam logic [42:0] LOAD_VEC [N_VEC] = '{
    {10'd0,    12'd5,  1'b0, 10'd77,   10'd7},
    {10'd7,    12'd2,  1'b0, 10'd17,   10'd12},
    {10'd12,   12'd3,  1'b1, 10'd300,  10'd4},
    {10'd4,    12'd10, 1'b0, 10'd5,    10'd1023},
    {10'd1023, 12'd40, 1'b1, 10'd1023, 10'd9},
    {10'd9,    12'd63, 1'b0, 10'd0,    10'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_we = 1'b0;
  logic [PTR_W-1:0] host_idx = '0;
  logic [1:0]       host_sel = '0;
  logic [15:0]      host_wdata = '0;
  logic             frame_start = 1'b0;
  logic             ts_valid = 1'b0;
  logic [TS_W-1:0]  ts_count = '0;
  logic             hit_valid;
  logic [CH_W-1:0]  hit_chan;
  logic             hit_loop;
  logic [TS_W-1:0]  hit_slot;

  int checks = 0;
  int errors = 0;

  // Bench-side view of the table, kept from the R2 encoding.
  logic [TS_W-1:0]  m_slot [N_ENTRY];
  logic [CH_W-1:0]  m_chan [N_ENTRY];
  logic             m_loop [N_ENTRY];
  logic [PTR_W-1:0] m_link [N_ENTRY];

  tdm_slot_map #(.N_ENTRY(N_ENTRY), .TS_W(TS_W), .CH_W(CH_W)) u_tdm_slot_map (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
    .host_sel(host_sel), .host_wdata(host_wdata), .frame_start(frame_start),
    .ts_valid(ts_valid), .ts_count(ts_count), .hit_valid(hit_valid),
    .hit_chan(hit_chan), .hit_loop(hit_loop), .hit_slot(hit_slot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=<%0d cycles", WATCHDOG, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N_ENTRY; i++) begin
      m_slot[i] = '0; m_chan[i] = '0; m_loop[i] = 1'b0; m_link[i] = '0;
    end
  endtask

  // R2: word 0 loop/channel, word 1 slot, word 2 link, word 3 nothing.
  task automatic model_write(input int idx, input logic [1:0] sel, input logic [15:0] d);
    case (sel)
      2'd0: begin m_chan[idx] = d[9:0]; m_loop[idx] = d[15]; end
      2'd1: m_slot[idx] = d[11:0];
      2'd2: m_link[idx] = d[9:0];
      default: ;
    endcase
  endtask

  task automatic host_write(input int idx, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_idx = PTR_W'(idx); host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    model_write(idx, sel, d);
  endtask

  // One frame. wr_at >= 0 puts a host write on that slot; wr_at == -2 puts
  // it on the frame-boundary cycle. gaps inserts idle cycles before slots.
  task automatic run_frame(input string req, input int wr_at, input int widx,
                           input logic [1:0] wsel, input logic [15:0] wd,
                           input bit gaps);
    int p;
    bit dead;
    bit exp_v;
    logic [CH_W-1:0] exp_c;
    logic exp_l;
    @(negedge clk);
    frame_start = 1'b1; ts_valid = 1'b0;
    p = int'(m_link[0]);
    dead = (wr_at == -2);
    if (dead) begin
      host_we = 1'b1; host_idx = PTR_W'(widx); host_sel = wsel; host_wdata = wd;
      model_write(widx, wsel, wd);
    end
    @(posedge clk); #1;
    check(hit_valid === 1'b0, {req, " R3 boundary"}, 32'(hit_valid), 32'd0);
    for (int s = 0; s < FRAME_SLOTS; s++) begin
      if (gaps) begin
        @(negedge clk);
        frame_start = 1'b0; host_we = 1'b0; ts_valid = 1'b0; ts_count = TS_W'(s);
        @(posedge clk); #1;
        check(hit_valid === 1'b0, {req, " R11 idle"}, 32'(hit_valid), 32'd0);
      end
      @(negedge clk);
      frame_start = 1'b0; ts_valid = 1'b1; ts_count = TS_W'(s);
      host_we = (s == wr_at);
      if (s == wr_at) begin
        host_idx = PTR_W'(widx); host_sel = wsel; host_wdata = wd;
        dead = 1'b1;
        model_write(widx, wsel, wd);
      end
      exp_v = !dead && (p != 0) && (int'(m_slot[p]) == s);
      exp_c = exp_v ? m_chan[p] : '0;
      exp_l = exp_v ? m_loop[p] : 1'b0;
      if (exp_v) p = int'(m_link[p]);
      @(posedge clk); #1;
      check(hit_valid === exp_v, {req, " valid"}, 32'(hit_valid), 32'(exp_v));
      if (exp_v)
        check(hit_chan === exp_c && hit_loop === exp_l && hit_slot === TS_W'(s),
              {req, " R4 fields"}, {hit_loop, 9'd0, hit_chan, hit_slot},
              {exp_l, 9'd0, exp_c, TS_W'(s)});
    end
    @(negedge clk);
    host_we = 1'b0; ts_valid = 1'b0;
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    check(hit_valid === 1'b0, "R1 in reset", 32'(hit_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(hit_valid === 1'b0, "R1 after reset", 32'(hit_valid), 32'd0);

    // R7 and R1: the table after reset is an empty list.
    run_frame("R7 empty after reset", -1, 0, 2'd0, 16'd0, 1'b0);

    // Load the vector table, with a reserved-word write per entry (R2).
    for (int v = 0; v < N_VEC; v++) begin
      host_write(int'(LOAD_VEC[v][42:33]), 2'd0,
                 {LOAD_VEC[v][20], 5'd0, LOAD_VEC[v][19:10]});
      host_write(int'(LOAD_VEC[v][42:33]), 2'd1, {4'd0, LOAD_VEC[v][32:21]});
      host_write(int'(LOAD_VEC[v][42:33]), 2'd2, {6'd0, LOAD_VEC[v][9:0]});
      host_write(int'(LOAD_VEC[v][42:33]), 2'd3, 16'hFFFF);
    end

    // R3 R4 R5 R8: the sentinel holds slot 5, which never hits; slots 2 and 3 are consecutive.
    run_frame("R5 R8 walk", -1, 0, 2'd0, 16'd0, 1'b0);
    // R6: the same walk repeats after the null link.
    run_frame("R6 repeat", -1, 0, 2'd0, 16'd0, 1'b0);
    // R11: idle cycles carrying the upcoming count.
    run_frame("R11 gaps", -1, 0, 2'd0, 16'd0, 1'b1);
    // R10: a mid-frame write relinks entry 12 past entry 4.
    run_frame("R10 mid write", 5, 12, 2'd2, 16'd1023, 1'b0);
    run_frame("R10 relinked", -1, 0, 2'd0, 16'd0, 1'b0);
    // R10 and R2: a reserved-word write on the boundary silences the frame only.
    run_frame("R10 boundary write", -2, 12, 2'd3, 16'hABCD, 1'b0);
    run_frame("R2 reserved kept", -1, 0, 2'd0, 16'd0, 1'b0);
    // R9: entry 1023 moved to slot 1, behind slot 3; the walk stalls there.
    host_write(1023, 2'd1, 16'd1);
    run_frame("R9 stall", -1, 0, 2'd0, 16'd0, 1'b0);
    // R7: the head link is cleared.
    host_write(0, 2'd2, 16'd0);
    run_frame("R7 empty", -1, 0, 2'd0, 16'd0, 1'b0);
    // R1: a reset clears a populated list.
    host_write(0, 2'd2, 16'd7);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_clear();
    run_frame("R1 reset clears", -1, 0, 2'd0, 16'd0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule